// File: doc/BRIEF.md
# Warm-Boot Reprogram Sequence Generator

This block sits between a control processor and the write FIFO of an on-chip configuration port. When it sees a trigger pulse, it does three things in order. First it checks the requested warm-boot address against a flash window given by a base and a size. Then it waits until the downstream FIFO reports enough free space. Finally it streams a fixed eight-word command sequence over a valid/ready interface. That sequence synchronises the port, loads the warm-boot start address register with the requested address, and writes the internal-reprogram command. Once the last word has been accepted, the block pulses a one-cycle request that tells the port controller to start draining the FIFO.

The configuration words are bit-packed Type 1 packet headers. Bits 31:29 hold 3'b001. Bits 28:27 hold the operation code: 01 means read and 10 means write. Bits 26:13 hold the register number and bits 10:0 hold the word count. The same packing logic drives a separate registered output that gives a read header for any register number the caller selects.

Top module: `wbseq_top`

## Requirements
- R1: After an accepted trigger, the block emits exactly eight words, in this order: 32'hFFFFFFFF, 32'hAA995566, 32'h20000000, 32'h30020001, the boot address latched at the trigger, 32'h30008001, 32'h0000000F, 32'h20000000.
- R2: A word counts as sent only on a cycle where wr_valid_o and wr_ready_i are both high. While wr_ready_i is low, wr_valid_o stays high and wr_data_o stays unchanged.
- R3: A trigger is rejected when its address is below flash_base_i or above flash_base_i + flash_size_i. A rejected trigger sends no words, issues no start request and leaves busy_o low. It sets range_err_o to 1, and range_err_o stays at 1 until the next accepted trigger clears it.
- R4: wr_valid_o does not rise until fifo_vacancy_i has been at least 8 on the previous cycle. While the vacancy stays below 8, no word is offered.
- R5: start_wr_o goes high for exactly one cycle, on the cycle right after the eighth word is accepted. It is issued once per accepted trigger.
- R6: busy_o goes high on the cycle after an accepted trigger and falls on the same cycle that start_wr_o rises. A trigger that arrives while busy_o is high is ignored: it does not change the emitted words and it does not set range_err_o.
- R7: rd_hdr_o equals 32'h28000000 | (rd_reg_i << 13), one clock after rd_reg_i is applied.
- R8: After reset, wr_valid_o, start_wr_o, busy_o and range_err_o are all 0.
- R9: The range bounds are inclusive. An address equal to flash_base_i, or equal to flash_base_i + flash_size_i, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | One-cycle request to start a reprogram sequence |
| boot_addr_i | input | 32 | Warm-boot start address, sampled with the trigger |
| flash_base_i | input | 32 | Lowest allowed boot address |
| flash_size_i | input | 32 | Window size; base + size is the highest allowed address |
| fifo_vacancy_i | input | VAC_W (10) | Free word slots in the downstream write FIFO |
| wr_valid_o | output | 1 | A configuration word is offered |
| wr_data_o | output | 32 | Offered configuration word |
| wr_ready_i | input | 1 | FIFO accepts the offered word |
| start_wr_o | output | 1 | One-cycle request to start the FIFO-to-port transfer |
| busy_o | output | 1 | A sequence is in progress |
| range_err_o | output | 1 | The last trigger was rejected as out of range |
| rd_reg_i | input | REG_W (14) | Register number for the read header |
| rd_hdr_o | output | 32 | Type 1 read header for rd_reg_i |

## Verification
The embedded assertions are checked on every cycle. They cover four properties: the held word under back-pressure, the vacancy gate on the first offered word, the single-cycle start pulse that follows an accepted handshake, and the rule that no word is offered and no error coexists with a busy block. Only the bench scenarios can show the rest. That includes the exact word order with the latched address, the inclusive range edges and the rejection of addresses just outside them, the way a trigger during busy is ignored, and the header values produced for chosen register numbers.

// File: rtl/wbseq_pkg.sv
package wbseq_pkg;
  localparam int WORD_W  = 32;
  localparam int SEQ_LEN = 8;
  localparam int IDX_W   = $clog2(SEQ_LEN);
  localparam int HREG_W  = 14;

  // Type 1 header fields
  localparam logic [2:0] PKT_T1   = 3'b001;
  localparam logic [1:0] OPC_NOP  = 2'b00;
  localparam logic [1:0] OPC_READ = 2'b01;
  localparam logic [1:0] OPC_WR   = 2'b10;

  localparam logic [HREG_W-1:0] REG_CMD    = 14'd4;
  localparam logic [HREG_W-1:0] REG_WSTART = 14'd16;

  localparam logic [WORD_W-1:0] W_PAD     = 32'hFFFF_FFFF;
  localparam logic [WORD_W-1:0] W_SYNC    = 32'hAA99_5566;
  localparam logic [WORD_W-1:0] W_REPROG  = 32'h0000_000F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROOM,
    ST_PUSH
  } seq_state_e;

  function automatic logic [WORD_W-1:0] t1_header(
    input logic [1:0]        opc,
    input logic [HREG_W-1:0] regno,
    input logic [10:0]       cnt
  );
    logic [WORD_W-1:0] h;
    h         = '0;
    h[31:29]  = PKT_T1;
    h[28:27]  = opc;
    h[26:13]  = regno;
    h[10:0]   = cnt;
    return h;
  endfunction
endpackage

// File: rtl/wbseq_range_chk.sv
module wbseq_range_chk #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] size_i,
  output logic          ok_o
);
  localparam int SW = AW + 1;
  logic [SW-1:0] upper;
  logic [SW-1:0] addr_x;

  always_comb begin
    upper  = {1'b0, base_i} + {1'b0, size_i};
    addr_x = {1'b0, addr_i};
    ok_o   = (addr_i >= base_i) && (addr_x <= upper);
  end
endmodule

// File: rtl/wbseq_word_sel.sv
module wbseq_word_sel
  import wbseq_pkg::*;
(
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] boot_addr_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    unique case (idx_i)
      3'd0:    word_o = W_PAD;
      3'd1:    word_o = W_SYNC;
      3'd2:    word_o = t1_header(OPC_NOP, '0, 11'd0);
      3'd3:    word_o = t1_header(OPC_WR, REG_WSTART, 11'd1);
      3'd4:    word_o = boot_addr_i;
      3'd5:    word_o = t1_header(OPC_WR, REG_CMD, 11'd1);
      3'd6:    word_o = W_REPROG;
      default: word_o = t1_header(OPC_NOP, '0, 11'd0);
    endcase
  end
endmodule

// File: rtl/wbseq_rd_hdr.sv
module wbseq_rd_hdr
  import wbseq_pkg::*;
#(
  parameter int REG_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  reg_i,
  output logic [WORD_W-1:0] hdr_o
);
  logic [HREG_W-1:0] reg_ext;

  generate
    if (REG_W < HREG_W) begin : g_pad
      assign reg_ext = {{(HREG_W-REG_W){1'b0}}, reg_i};
    end else begin : g_trim
      assign reg_ext = reg_i[HREG_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hdr_o <= '0;
    else     hdr_o <= t1_header(OPC_READ, reg_ext, 11'd0);
  end
endmodule

// File: rtl/wbseq_top.sv
module wbseq_top
  import wbseq_pkg::*;
#(
  parameter int VAC_W = 10,
  parameter int REG_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic [31:0]       boot_addr_i,
  input  logic [31:0]       flash_base_i,
  input  logic [31:0]       flash_size_i,
  input  logic [VAC_W-1:0]  fifo_vacancy_i,
  output logic              wr_valid_o,
  output logic [31:0]       wr_data_o,
  input  logic              wr_ready_i,
  output logic              start_wr_o,
  output logic              busy_o,
  output logic              range_err_o,
  input  logic [REG_W-1:0]  rd_reg_i,
  output logic [31:0]       rd_hdr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
  localparam logic [VAC_W-1:0] NEED_VAC = VAC_W'(SEQ_LEN);

  seq_state_e        state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  sel_idx;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] sel_word;
  logic              addr_ok;
  logic              accept;

  wbseq_range_chk #(.AW(WORD_W)) u_range (
    .addr_i (boot_addr_i),
    .base_i (flash_base_i),
    .size_i (flash_size_i),
    .ok_o   (addr_ok)
  );

  assign sel_idx = (state == ST_PUSH) ? idx + 1'b1 : '0;
  assign accept  = wr_valid_o && wr_ready_i;

  wbseq_word_sel u_words (
    .idx_i       (sel_idx),
    .boot_addr_i (addr_q),
    .word_o      (sel_word)
  );

  wbseq_rd_hdr #(.REG_W(REG_W)) u_hdr (
    .clk   (clk),
    .rst   (rst),
    .reg_i (rd_reg_i),
    .hdr_o (rd_hdr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      idx         <= '0;
      addr_q      <= '0;
      wr_valid_o  <= 1'b0;
      wr_data_o   <= '0;
      start_wr_o  <= 1'b0;
      busy_o      <= 1'b0;
      range_err_o <= 1'b0;
    end else begin
      start_wr_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (trig_i) begin
            if (addr_ok) begin
              addr_q      <= boot_addr_i;
              range_err_o <= 1'b0;
              busy_o      <= 1'b1;
              state       <= ST_ROOM;
            end else begin
              range_err_o <= 1'b1;
            end
          end
        end
        ST_ROOM: begin
          if (fifo_vacancy_i >= NEED_VAC) begin
            idx        <= '0;
            wr_valid_o <= 1'b1;
            wr_data_o  <= sel_word;
            state      <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (accept) begin
            if (idx == LAST_IDX) begin
              wr_valid_o <= 1'b0;
              start_wr_o <= 1'b1;
              busy_o     <= 1'b0;
              state      <= ST_IDLE;
            end else begin
              idx       <= idx + 1'b1;
              wr_data_o <= sel_word;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: offered word held under back-pressure
  a_r2_hold_word: assert property (@(posedge clk) disable iff (rst)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_data_o)));

  // R4: first word only after enough room
  a_r4_room_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_valid_o) |-> ($past(fifo_vacancy_i) >= NEED_VAC));

  // R5: start follows an accepted word and lasts one cycle
  a_r5_start_after_push: assert property (@(posedge clk) disable iff (rst)
    start_wr_o |-> $past(wr_valid_o && wr_ready_i));
  a_r5_start_single: assert property (@(posedge clk) disable iff (rst)
    start_wr_o |=> !start_wr_o);

  // R6: nothing offered while not busy
  a_r6_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !wr_valid_o);

  // R3: error never coexists with an active sequence
  a_r3_err_not_busy: assert property (@(posedge clk) disable iff (rst)
    range_err_o |-> !busy_o);
endmodule

// File: tb/wbseq_top_bench.sv
module wbseq_top_bench;
  localparam int VAC_W = 10;
  localparam int REG_W = 14;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              trig = 1'b0;
  logic [31:0]       boot_addr = '0;
  logic [31:0]       fbase = '0;
  logic [31:0]       fsize = '0;
  logic [VAC_W-1:0]  vac = '0;
  logic              wr_valid;
  logic [31:0]       wr_data;
  logic              wr_ready = 1'b1;
  logic              start_wr;
  logic              busy;
  logic              rerr;
  logic [REG_W-1:0]  rd_reg = '0;
  logic [31:0]       rd_hdr;

  int checks = 0;
  int fails  = 0;
  int nwords = 0;
  int starts = 0;
  bit rand_ready = 1'b0;
  logic [31:0] got [0:15];

  always #4 clk = ~clk;

  wbseq_top #(.VAC_W(VAC_W), .REG_W(REG_W)) u_wbseq_top (
    .clk(clk), .rst(rst), .trig_i(trig), .boot_addr_i(boot_addr),
    .flash_base_i(fbase), .flash_size_i(fsize), .fifo_vacancy_i(vac),
    .wr_valid_o(wr_valid), .wr_data_o(wr_data), .wr_ready_i(wr_ready),
    .start_wr_o(start_wr), .busy_o(busy), .range_err_o(rerr),
    .rd_reg_i(rd_reg), .rd_hdr_o(rd_hdr)
  );

  function automatic logic [31:0] exp_word(input int i, input logic [31:0] a);
    case (i)
      0: return 32'hFFFF_FFFF;
      1: return 32'hAA99_5566;
      2: return 32'h2000_0000;
      3: return 32'h3002_0001;
      4: return a;
      5: return 32'h3000_8001;
      6: return 32'h0000_000F;
      default: return 32'h2000_0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_hdr(input logic [REG_W-1:0] r);
    return 32'h2800_0000 | (32'(r) << 13);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // monitor: handshake completes at the next posedge
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_valid && wr_ready) begin
        if (nwords < 16) got[nwords] = wr_data;
        nwords++;
      end
      if (start_wr) starts++;
    end
  end

  // random back-pressure
  always begin
    @(posedge clk); #2;
    if (rand_ready) wr_ready = ($urandom % 4) != 0;
    else            wr_ready = 1'b1;
  end

  task automatic smp();
    @(negedge clk); #1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_trig(input logic [31:0] a);
    boot_addr = a;
    trig = 1'b1;
    cyc(1);
    trig = 1'b0;
  endtask

  task automatic run_good(input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] s, input string tag);
    int s0;
    bit seen;
    cyc(1);
    fbase = b; fsize = s; vac = VAC_W'($urandom % 8);
    nwords = 0;
    s0 = starts;
    pulse_trig(a);
    boot_addr = ~a;
    cyc(2);
    pulse_trig(b + s + 32'd5); // R6: during busy, would be out of range
    cyc(2);
    smp();
    chk(busy === 1'b1, {"R6 busy held ", tag}, 32'(busy), 32'd1);
    chk(nwords == 0 && !wr_valid, {"R4 no words without room ", tag}, 32'(nwords), 32'd0);
    cyc(1);
    vac = VAC_W'(8 + $urandom % 20);
    seen = 1'b0;
    for (int k = 0; k < 300 && !seen; k++) begin
      smp();
      if (start_wr) seen = 1'b1;
    end
    chk(seen, {"R5 start issued ", tag}, 32'(seen), 32'd1);
    chk(busy === 1'b0, {"R6 busy low at start ", tag}, 32'(busy), 32'd0);
    chk(nwords == 8, {"R1 word count ", tag}, 32'(nwords), 32'd8);
    for (int i = 0; i < 8; i++)
      chk(got[i] === exp_word(i, a), {"R1 word order ", tag}, got[i], exp_word(i, a));
    cyc(4);
    smp();
    chk(starts == s0 + 1, {"R5 single start ", tag}, 32'(starts - s0), 32'd1);
    chk(rerr === 1'b0, {"R6 ignored trigger no error ", tag}, 32'(rerr), 32'd0);
    chk(nwords == 8, {"R2 no extra words ", tag}, 32'(nwords), 32'd8);
  endtask

  task automatic run_bad(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] s, input string tag);
    int s0;
    cyc(1);
    fbase = b; fsize = s; vac = 10'd64;
    nwords = 0;
    s0 = starts;
    pulse_trig(a);
    cyc(2);
    smp();
    chk(rerr === 1'b1, {"R3 error raised ", tag}, 32'(rerr), 32'd1);
    chk(busy === 1'b0, {"R3 not busy ", tag}, 32'(busy), 32'd0);
    cyc(20);
    smp();
    chk(nwords == 0 && starts == s0, {"R3 nothing sent ", tag}, 32'(nwords), 32'd0);
    chk(rerr === 1'b1, {"R3 error sticky ", tag}, 32'(rerr), 32'd1);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_up();
  end

  initial begin
    logic [31:0] b, s, a;
    int seed;
    seed = $urandom(32'd4242);
    cyc(4);
    rst = 1'b0;
    smp();
    chk(!wr_valid && !start_wr && !busy && !rerr, "R8 reset state",
        {28'd0, wr_valid, start_wr, busy, rerr}, 32'd0);

    // R7 header builder
    rd_reg = 14'd16;
    cyc(1); smp();
    chk(rd_hdr === 32'h2802_0000, "R7 header reg16", rd_hdr, 32'h2802_0000);
    for (int i = 0; i < 6; i++) begin
      rd_reg = REG_W'($urandom);
      cyc(1); smp();
      chk(rd_hdr === exp_hdr(rd_reg), "R7 header random", rd_hdr, exp_hdr(rd_reg));
    end

    // directed boundaries R9 / R3
    run_good(32'h1000_0000, 32'h1000_0000, 32'h0100_0000, "R9 at base");
    run_good(32'h1100_0000, 32'h1000_0000, 32'h0100_0000, "R9 at top");
    run_bad (32'h0FFF_FFFF, 32'h1000_0000, 32'h0100_0000, "below base");
    run_bad (32'h1100_0001, 32'h1000_0000, 32'h0100_0000, "above top");
    run_good(32'h1080_0000, 32'h1000_0000, 32'h0100_0000, "R3 clears error");

    // random scenarios with back-pressure (R2)
    rand_ready = 1'b1;
    for (int t = 0; t < 6; t++) begin
      b = $urandom % 32'h4000_0000;
      s = 1 + $urandom % 32'h0100_0000;
      a = b + ($urandom % (s + 1));
      run_good(a, b, s, "R2 random");
    end
    for (int t = 0; t < 3; t++) begin
      b = 32'h0010_0000 + $urandom % 32'h4000_0000;
      s = 1 + $urandom % 32'h0100_0000;
      if (t[0]) a = b + s + 1 + ($urandom % 1000);
      else      a = b - 1 - ($urandom % 1000);
      run_bad(a, b, s, "random");
    end
    rand_ready = 1'b0;
    finish_up();
  end
endmodule